// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a memory-mapped watchdog whose counter runs on an oscillator clock while its register interface runs on a bus clock. Software sets a coarse period, optionally restarts the elapsed count, and then turns counting on. Writing the service bit of the interrupt register keeps the watchdog alive. If the count reaches the end of a period with no service, the interrupt goes high. If a second full period then passes with no service, a one-cycle reset pulse is driven to the system reset controller.

Written values cross from the bus domain into the oscillator domain as a held value and a toggle strobe. Software must therefore space its writes by the crossing latency. A separate software path asks for an immediate reset, and a mode bit can mask that path. Once counting has started, the period and the run bit are frozen. Only a module reset brings the block back to idle.

Top module: `wdt_dual_overflow`

## Requirements
- R1: After reset, `irq` and `wdt_rst` are low and every register reads as zero.
- R2: Register offsets are: 0x00 run control (bit 0), 0x04 period, 0x08 elapsed restart, 0x0C interrupt/service (bit 0), 0x10 reset-request mask (bit 0), 0x14 reset request (bit 0). The period value N is held only in the top PERIOD_BITS bits of 0x04 (bits 31:20 by default). All lower bits are dropped on write and read as zero.
- R3: While the run bit is clear, the block never counts and `irq` stays low. Once the run bit is set, `irq` rises 2^PRESCALE_BITS × (N+1) oscillator cycles after counting begins.
- R4: If the watchdog is not serviced after `irq` rises, `wdt_rst` pulses high exactly 2^PRESCALE_BITS × (N+1) oscillator cycles later. The pulse lasts one oscillator cycle, and `irq` is low again in the following cycle.
- R5: Writing 1 to bit 0 of 0x0C clears the count and the pending interrupt. Regular servicing keeps both `irq` and `wdt_rst` low. After a clear, the next overflow only raises `irq`.
- R6: Writing the value 0 to 0x08 restarts the count from zero, and the next `irq` comes a full period after that write.
- R7: While the watchdog is running, writes to 0x04 and 0x00 change neither the readback nor the period timing. A write of 0 to 0x00 does not stop the watchdog.
- R8: Writing 1 to bit 0 of 0x14 produces exactly one `wdt_rst` pulse when bit 0 of 0x10 is 0, and no pulse when that bit is 1. Bit 0 of 0x10 reads back as written.
- R9: Bit 0 of 0x0C reads as 1 while the interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| osc_clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | First-overflow interrupt, oscillator domain |
| wdt_rst | output | 1 | One-cycle reset request, oscillator domain |

## Verification
A corrupted prescaler or period count moves the `irq` edge away from its computed cycle. The first overflow therefore shows the fault within one period of enabling. A lost or stuck overflow flag shows up within two periods: the reset pulse either comes on the first overflow or never comes, or it is wider than one cycle. A broken lock or mask in the register stage shows up immediately as a wrong readback. One period later it also shows up as a changed interval between `irq` and `wdt_rst`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_RUN     = 32'h00;
  localparam int unsigned OFS_PERIOD  = 32'h04;
  localparam int unsigned OFS_ELAPSED = 32'h08;
  localparam int unsigned OFS_SVC     = 32'h0C;
  localparam int unsigned OFS_RQMASK  = 32'h10;
  localparam int unsigned OFS_RQ      = 32'h14;

  typedef enum logic [1:0] {
    CFG_RUN     = 2'd0,
    CFG_PERIOD  = 2'd1,
    CFG_RESTART = 2'd2
  } cfg_op_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/wdt_pulse_xing.sv
module wdt_pulse_xing #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic              tgl_q, tgl_d;
  logic [STAGES:0]   sync_q, sync_d;

  always_comb tgl_d = tgl_q ^ src_pulse;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  always_comb sync_d = {sync_q[STAGES-1:0], tgl_q};

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= '0;
    else            sync_q <= sync_d;
  end

  assign dst_pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PERIOD_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic                   irq_async,
  output logic                   cfg_pulse,
  output cfg_op_e                cfg_op,
  output logic [PERIOD_BITS-1:0] cfg_period,
  output logic                   svc_pulse,
  output logic                   rq_pulse
);
  localparam int LOW_BITS = 32 - PERIOD_BITS;
  localparam logic [ADDR_W-1:0] A_RUN     = ADDR_W'(OFS_RUN);
  localparam logic [ADDR_W-1:0] A_PERIOD  = ADDR_W'(OFS_PERIOD);
  localparam logic [ADDR_W-1:0] A_ELAPSED = ADDR_W'(OFS_ELAPSED);
  localparam logic [ADDR_W-1:0] A_SVC     = ADDR_W'(OFS_SVC);
  localparam logic [ADDR_W-1:0] A_RQMASK  = ADDR_W'(OFS_RQMASK);
  localparam logic [ADDR_W-1:0] A_RQ      = ADDR_W'(OFS_RQ);

  logic                   run_q, run_d;
  logic [PERIOD_BITS-1:0] period_q, period_d;
  logic                   mask_q, mask_d;
  cfg_op_e                op_q, op_d;
  logic [31:0]            rdata_q, rdata_d;
  logic                   irq_meta_q, irq_sync_q;
  logic                   wr, rd;

  assign wr = sel & we;
  assign rd = sel & ~we;

  always_comb begin
    run_d     = run_q;
    period_d  = period_q;
    mask_d    = mask_q;
    op_d      = op_q;
    cfg_pulse = 1'b0;
    svc_pulse = 1'b0;
    rq_pulse  = 1'b0;
    if (wr) begin
      if (addr == A_RUN && wdata[0] && !run_q) begin
        run_d     = 1'b1;
        op_d      = CFG_RUN;
        cfg_pulse = 1'b1;
      end
      if (addr == A_PERIOD && !run_q) begin
        period_d  = wdata[31 -: PERIOD_BITS];
        op_d      = CFG_PERIOD;
        cfg_pulse = 1'b1;
      end
      if (addr == A_ELAPSED && wdata == 32'd0) begin
        op_d      = CFG_RESTART;
        cfg_pulse = 1'b1;
      end
      if (addr == A_SVC && wdata[0]) svc_pulse = 1'b1;
      if (addr == A_RQMASK) mask_d = wdata[0];
      if (addr == A_RQ && wdata[0] && !mask_q) rq_pulse = 1'b1;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) begin
      case (addr)
        A_RUN:    rdata_d = {31'd0, run_q};
        A_PERIOD: rdata_d = {period_q, {LOW_BITS{1'b0}}};
        A_SVC:    rdata_d = {31'd0, irq_sync_q};
        A_RQMASK: rdata_d = {31'd0, mask_q};
        default:  rdata_d = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      period_q   <= '0;
      mask_q     <= 1'b0;
      op_q       <= CFG_RUN;
      rdata_q    <= 32'd0;
      irq_meta_q <= 1'b0;
      irq_sync_q <= 1'b0;
    end else begin
      run_q      <= run_d;
      period_q   <= period_d;
      mask_q     <= mask_d;
      op_q       <= op_d;
      rdata_q    <= rdata_d;
      irq_meta_q <= irq_async;
      irq_sync_q <= irq_meta_q;
    end
  end

  assign rdata      = rdata_q;
  assign cfg_op     = op_q;
  assign cfg_period = period_q;

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_PERIOD) |=> (rdata[LOW_BITS-1:0] == '0));

  a_r7_bus_lock: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (run_q && $stable(period_q)));

  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !rq_pulse);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PRESCALE_BITS = 20,
  parameter int PERIOD_BITS   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_pulse,
  input  cfg_op_e                cfg_op,
  input  logic [PERIOD_BITS-1:0] cfg_period,
  input  logic                   svc_pulse,
  input  logic                   rq_pulse,
  output logic                   irq,
  output logic                   wdt_rst
);
  logic [PRESCALE_BITS-1:0] pre_q, pre_d;
  logic [PERIOD_BITS-1:0]   per_q, per_d;
  logic [PERIOD_BITS-1:0]   lim_q, lim_d;
  logic                     run_q, run_d;
  logic                     flag_q, flag_d;
  logic                     rst_q, rst_d;
  logic                     wrap, hit;

  assign wrap = run_q && (&pre_q);
  assign hit  = wrap && (per_q == lim_q);

  always_comb begin
    pre_d  = pre_q;
    per_d  = per_q;
    lim_d  = lim_q;
    run_d  = run_q;
    flag_d = flag_q;
    rst_d  = 1'b0;
    if (run_q) begin
      pre_d = pre_q + PRESCALE_BITS'(1);
      if (wrap) per_d = hit ? '0 : per_q + PERIOD_BITS'(1);
      if (hit) begin
        if (flag_q) begin
          rst_d  = 1'b1;
          flag_d = 1'b0;
        end else begin
          flag_d = 1'b1;
        end
      end
    end
    if (cfg_pulse) begin
      case (cfg_op)
        CFG_RUN:     if (!run_q) run_d = 1'b1;
        CFG_PERIOD:  if (!run_q) lim_d = cfg_period;
        CFG_RESTART: begin
          pre_d = '0;
          per_d = '0;
        end
        default: ;
      endcase
    end
    if (svc_pulse) begin
      pre_d  = '0;
      per_d  = '0;
      flag_d = 1'b0;
    end
    if (rq_pulse) rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      per_q  <= '0;
      lim_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      per_q  <= per_d;
      lim_q  <= lim_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      rst_q  <= rst_d;
    end
  end

  assign irq     = flag_q;
  assign wdt_rst = rst_q;

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!flag_q && pre_q == '0 && per_q == '0));

  a_r4_needs_first_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_d && !rq_pulse) |-> flag_q);

  a_r4_flag_drops_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_d && !rq_pulse && !svc_pulse) |=> !irq);

  a_r5_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |=> !irq);

  a_r7_core_lock: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (run_q && $stable(lim_q)));
endmodule

// File: rtl/wdt_dual_overflow.sv
module wdt_dual_overflow
  import wdt_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int PERIOD_BITS   = 12,
  parameter int PRESCALE_BITS = 20,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              bus_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic                   bus_rst_n, osc_rst_n;
  logic                   cfg_pulse_b, svc_pulse_b, rq_pulse_b;
  logic                   cfg_pulse_o, svc_pulse_o, rq_pulse_o;
  cfg_op_e                cfg_op;
  logic [PERIOD_BITS-1:0] cfg_period;
  logic                   irq_int;

  wdt_rst_sync u_bus_rst (.clk(bus_clk), .arst_n(rst_n), .rst_n_o(bus_rst_n));
  wdt_rst_sync u_osc_rst (.clk(osc_clk), .arst_n(rst_n), .rst_n_o(osc_rst_n));

  wdt_regs #(.ADDR_W(ADDR_W), .PERIOD_BITS(PERIOD_BITS)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .irq_async(irq_int),
    .cfg_pulse(cfg_pulse_b), .cfg_op(cfg_op), .cfg_period(cfg_period),
    .svc_pulse(svc_pulse_b), .rq_pulse(rq_pulse_b)
  );

  wdt_pulse_xing #(.STAGES(SYNC_STAGES)) u_x_cfg (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_pulse(cfg_pulse_b),
    .dst_clk(osc_clk), .dst_rst_n(osc_rst_n), .dst_pulse(cfg_pulse_o));
  wdt_pulse_xing #(.STAGES(SYNC_STAGES)) u_x_svc (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_pulse(svc_pulse_b),
    .dst_clk(osc_clk), .dst_rst_n(osc_rst_n), .dst_pulse(svc_pulse_o));
  wdt_pulse_xing #(.STAGES(SYNC_STAGES)) u_x_rq (
    .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_pulse(rq_pulse_b),
    .dst_clk(osc_clk), .dst_rst_n(osc_rst_n), .dst_pulse(rq_pulse_o));

  wdt_core #(.PRESCALE_BITS(PRESCALE_BITS), .PERIOD_BITS(PERIOD_BITS)) u_core (
    .clk(osc_clk), .rst_n(osc_rst_n),
    .cfg_pulse(cfg_pulse_o), .cfg_op(cfg_op), .cfg_period(cfg_period),
    .svc_pulse(svc_pulse_o), .rq_pulse(rq_pulse_o),
    .irq(irq_int), .wdt_rst(wdt_rst)
  );

  assign irq = irq_int;

  a_r4_single_pulse: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (wdt_rst && !rq_pulse_o && !$past(rq_pulse_o)) |=> !wdt_rst);
endmodule

// File: tb/tb_wdt_dual_overflow.sv
`timescale 1ns/1ps
module tb_wdt_dual_overflow;
  localparam int AW = 5;
  localparam int PB = 3;
  localparam int PS = 3;
  localparam int SH = 32 - PB;

  logic        bus_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst;

  int n_chk = 0, n_bad = 0;
  int osc_cyc = 0, irq_rises = 0, irq_rise_at = 0, rst_cnt = 0, rst_at = 0, rst_wide = 0;
  logic irq_q = 1'b0, rst_q = 1'b0;
  bit done = 0;

  wdt_dual_overflow #(.ADDR_W(AW), .PERIOD_BITS(PB), .PRESCALE_BITS(PS)) dut (
    .bus_clk(bus_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst));

  always #2 bus_clk = ~bus_clk;
  initial begin
    #1;
    forever #5 osc_clk = ~osc_clk;
  end

  always @(negedge osc_clk) begin
    osc_cyc = osc_cyc + 1;
    if (irq && !irq_q) begin
      irq_rises = irq_rises + 1;
      irq_rise_at = osc_cyc;
    end
    irq_q = irq;
    if (wdt_rst) begin
      rst_cnt = rst_cnt + 1;
      rst_at = osc_cyc;
      if (rst_q) rst_wide = rst_wide + 1;
    end
    rst_q = wdt_rst;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    repeat (30) @(negedge bus_clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge bus_clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge bus_clk);
    rst_n = 1'b0;
    repeat (6) @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (12) @(negedge bus_clk);
  endtask

  task automatic wait_irq(input int old);
    int g = 0;
    while (irq_rises == old && g < 20000) begin
      @(negedge bus_clk);
      g++;
    end
  endtask

  task automatic wait_rst(input int old);
    int g = 0;
    while (rst_cnt == old && g < 20000) begin
      @(negedge bus_clk);
      g++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int t0, i0, r0, per;

    // R1: reset state
    do_reset();
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(wdt_rst == 1'b0, "R1 wdt_rst", int'(wdt_rst), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a * 4, v);
      chk(v == 32'd0, "R1 readback", int'(v), 0);
    end

    // R3: no counting while the run bit is clear
    i0 = irq_rises; r0 = rst_cnt;
    wr(32'h04, 32'h2000_0000);
    repeat (300) @(negedge osc_clk);
    chk(irq_rises == i0, "R3 idle irq", irq_rises - i0, 0);
    chk(rst_cnt == r0, "R3 idle rst", rst_cnt - r0, 0);

    // R2 R3 R4 R9: sweep every period value
    for (int n = 0; n < (1 << PB); n++) begin
      do_reset();
      per = (1 << PS) * (n + 1);
      wr(32'h04, (32'(n) << SH) | 32'h1555_5555);
      rd(32'h04, v);
      chk(v == (32'(n) << SH), "R2 period mask", int'(v), int'(32'(n) << SH));
      i0 = irq_rises; r0 = rst_cnt;
      t0 = osc_cyc;
      wr(32'h00, 32'h1);
      wait_irq(i0);
      chk(irq_rise_at - t0 >= per && irq_rise_at - t0 <= per + 7,
          "R3 first overflow", irq_rise_at - t0, per);
      if (n >= 2) begin
        repeat (4) @(negedge bus_clk);
        rd(32'h0C, v);
        chk(v == 32'd1, "R9 pending readback", int'(v), 1);
      end
      wait_rst(r0);
      chk(rst_at - irq_rise_at == per, "R4 second overflow", rst_at - irq_rise_at, per);
      @(negedge osc_clk);
      chk(irq == 1'b0, "R4 irq after reset", int'(irq), 0);
      chk(rst_wide == 0, "R4 single pulse", rst_wide, 0);
    end

    // R5: servicing keeps it quiet
    do_reset();
    wr(32'h04, 32'd3 << SH);
    wr(32'h00, 32'h1);
    i0 = irq_rises; r0 = rst_cnt;
    for (int k = 0; k < 15; k++) wr(32'h0C, 32'h1);
    chk(irq_rises == i0, "R5 serviced irq", irq_rises - i0, 0);
    chk(rst_cnt == r0, "R5 serviced rst", rst_cnt - r0, 0);
    wait_irq(i0);
    i0 = irq_rises;
    wr(32'h0C, 32'h1);
    chk(irq == 1'b0, "R5 clear drops irq", int'(irq), 0);
    rd(32'h0C, v);
    chk(v == 32'd0, "R5 cleared readback", int'(v), 0);
    wait_irq(i0);
    chk(rst_cnt == r0, "R5 next overflow only irq", rst_cnt - r0, 0);

    // R6: elapsed restart
    do_reset();
    wr(32'h04, 32'd3 << SH);
    wr(32'h00, 32'h1);
    repeat (8) @(negedge osc_clk);
    i0 = irq_rises;
    t0 = osc_cyc;
    wr(32'h08, 32'd0);
    wait_irq(i0);
    chk(irq_rise_at - t0 >= 32 && irq_rise_at - t0 <= 39, "R6 restart delays irq",
        irq_rise_at - t0, 32);

    // R7: lock while running
    do_reset();
    wr(32'h04, 32'd1 << SH);
    wr(32'h00, 32'h1);
    wr(32'h04, 32'd7 << SH);
    wr(32'h00, 32'h0);
    rd(32'h04, v);
    chk(v == (32'd1 << SH), "R7 period locked", int'(v), int'(32'd1 << SH));
    rd(32'h00, v);
    chk(v == 32'd1, "R7 run locked", int'(v), 1);
    wait_rst(rst_cnt);
    i0 = irq_rises; r0 = rst_cnt;
    wait_irq(i0);
    wait_rst(r0);
    chk(rst_at - irq_rise_at == 16, "R7 timing unchanged", rst_at - irq_rise_at, 16);

    // R8: software reset request and its mask
    do_reset();
    wr(32'h10, 32'h1);
    rd(32'h10, v);
    chk(v == 32'd1, "R8 mask readback", int'(v), 1);
    r0 = rst_cnt;
    wr(32'h14, 32'h1);
    chk(rst_cnt == r0, "R8 masked request", rst_cnt - r0, 0);
    wr(32'h10, 32'h0);
    wr(32'h14, 32'h1);
    chk(rst_cnt == r0 + 1, "R8 request pulses", rst_cnt - r0, 1);
    chk(rst_wide == 0, "R8 single pulse", rst_wide, 0);

    done = 1;
    summary();
  end
endmodule